// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address into a physical address after a translation-cache miss. It reads a two-level table that lives in memory. A caller presents the linear address together with the kind of access, read or write, from user or supervisor mode. The walker then fetches the first-level (directory) entry and the second-level (table) entry over a simple request/acknowledge memory bus, one 32-bit word at a time.

It checks presence and access rights at both levels. The effective write and user rights are the AND of the two levels. When the walk is allowed, the walker sets the accessed flag in both entries and the dirty flag in the table entry by writing them back. It writes an entry back only when a flag actually changes. A walk that faults leaves memory untouched.

The result is either the physical address with the final table-entry flags, or a fault code. The fault code separates an absent entry from a rights violation and names the level that failed. The result stays on the outputs until the next walk completes.

Top module: `pgwalk_top`

## Requirements
- R1: During and after reset, walk_busy, walk_done, mem_req, walk_fault and walk_pa are all zero.
- R2: The first memory read of a walk is at dir_base + 4 × linear[31:22], where dir_base is sampled when the request is accepted. The second read is at {directory entry[31:12], linear[21:12], 2'b00}.
- R3: On a successful walk, walk_pa = {table entry[31:12], linear[11:0]}, walk_fault = 0 and walk_flevel = 0. walk_attr is the table entry's bits [11:0] after the flag update.
- R4: Bit 0 of an entry is its present flag. If it is clear in the directory entry, the walk ends with walk_fault = 1 and walk_flevel = 0 after exactly one read. If it is clear in the table entry, the walk ends with walk_fault = 1 and walk_flevel = 1. On any fault, walk_pa and walk_attr are zero.
- R5: Bit 1 is the write right and bit 2 is the user right. A user access fails with walk_fault = 2 when the user right is clear, and a user write also fails when the write right is clear. Directory bits are checked before the table is read, giving walk_flevel = 0. Table bits are checked afterwards, giving walk_flevel = 1.
- R6: A supervisor access never ends with walk_fault = 2, whatever the write and user rights are.
- R7: On an allowed walk, bit 5 (accessed) is set in both entries in memory. Bit 6 (dirty) is set in the table entry only for a write. All other bits are written back unchanged, and a read never sets bit 6.
- R8: An entry is written back only when its write-back would change it. A faulting walk performs no memory write.
- R9: A request is taken only while walk_busy is low. walk_busy is high from the cycle after acceptance until completion. walk_done is a one-cycle pulse coinciding with walk_busy falling. A request raised while busy is ignored, and the results stay unchanged until the next walk completes.
- R10: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base | input | 32 | Physical byte address of the directory |
| walk_req | input | 1 | Start a walk (taken when not busy) |
| walk_lin | input | 32 | Linear address to translate |
| walk_wr | input | 1 | 1 = write access, 0 = read |
| walk_user | input | 1 | 1 = user access, 0 = supervisor |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_pa | output | 32 | Physical address (zero on fault) |
| walk_attr | output | 12 | Updated table-entry flags (zero on fault) |
| walk_fault | output | 2 | 0 none, 1 not present, 2 protection |
| walk_flevel | output | 1 | Faulting level: 0 directory, 1 table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | One-cycle acknowledge, rdata valid with it |
| mem_rdata | input | 32 | Read data |

## Verification
Directed walks each isolate one ending: absent directory, absent table, user denied at each level, supervisor write to a read-only non-user page, entries whose flags are already set, and a read with accessed clear. Together they separate the fault kind, the fault level, the number of reads, and whether each entry is rewritten. Several hundred random walks follow, with random flags, present bits, access kinds and memory latencies. They show whether the AND of the two levels' rights and the conditional write-back agree with a bench model in every combination. Write counts, read addresses and final memory contents are compared alongside the outputs. One walk also raises a second request while busy, to show that it is dropped.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_ABSENT = 2'd1,
      FK_PROT   = 2'd2
   } fkind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_CHK_DIR,
      ST_RD_TBL,
      ST_CHK_TBL,
      ST_WR_DIR,
      ST_WR_TBL
   } wstate_e;

   localparam int unsigned FL_P = 0;
   localparam int unsigned FL_W = 1;
   localparam int unsigned FL_U = 2;
   localparam int unsigned FL_A = 5;
   localparam int unsigned FL_D = 6;

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm #(
   parameter bit SUPER_WRITE_CHECK = 1'b0
) (
   input  logic pres_bit,
   input  logic wr_bit,
   input  logic usr_bit,
   input  logic acc_wr,
   input  logic acc_user,
   output logic present,
   output logic allowed
);

   logic wr_ok;

   assign present = pres_bit;
   assign wr_ok   = !acc_wr || wr_bit;

   generate
      if (SUPER_WRITE_CHECK) begin : g_strict
         assign allowed = acc_user ? (usr_bit && wr_ok) : wr_ok;
      end else begin : g_relaxed
         assign allowed = !acc_user || (usr_bit && wr_ok);
      end
   endgenerate

endmodule

// File: rtl/pgwalk_upd.sv
module pgwalk_upd
   import pgwalk_pkg::*;
#(
   parameter int unsigned ENTRY_W = 32
) (
   input  logic [ENTRY_W-1:0] pde,
   input  logic [ENTRY_W-1:0] pte,
   input  logic               acc_wr,
   output logic               dir_need,
   output logic [ENTRY_W-1:0] dir_wdata,
   output logic               tbl_need,
   output logic [ENTRY_W-1:0] tbl_wdata
);

   logic [ENTRY_W-1:0] dir_mask;
   logic [ENTRY_W-1:0] tbl_mask;

   always_comb begin
      dir_mask       = '0;
      dir_mask[FL_A] = 1'b1;
      tbl_mask       = '0;
      tbl_mask[FL_A] = 1'b1;
      tbl_mask[FL_D] = acc_wr;
   end

   assign dir_wdata = pde | dir_mask;
   assign tbl_wdata = pte | tbl_mask;
   assign dir_need  = (pde & dir_mask) != dir_mask;
   assign tbl_need  = (pte & tbl_mask) != tbl_mask;

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
   import pgwalk_pkg::*;
#(
   parameter int unsigned LIN_W     = 32,
   parameter int unsigned DIR_IDX_W = 10,
   parameter int unsigned TBL_IDX_W = 10,
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned ENTRY_W   = 32,
   parameter int unsigned NUM_LVL   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ENTRY_W-1:0]   dir_base,
   input  logic                 walk_req,
   input  logic [LIN_W-1:0]     walk_lin,
   input  logic                 walk_wr,
   input  logic                 walk_user,
   input  logic                 mem_ack,
   input  logic [ENTRY_W-1:0]   mem_rdata,
   input  logic [NUM_LVL-1:0]   lvl_present,
   input  logic [NUM_LVL-1:0]   lvl_allowed,
   input  logic                 dir_need,
   input  logic [ENTRY_W-1:0]   dir_wdata,
   input  logic                 tbl_need,
   input  logic [ENTRY_W-1:0]   tbl_wdata,
   output logic                 walk_busy,
   output logic                 walk_done,
   output logic [ENTRY_W-1:0]   walk_pa,
   output logic [OFF_W-1:0]     walk_attr,
   output logic [1:0]           walk_fault,
   output logic                 walk_flevel,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ENTRY_W-1:0]   mem_addr,
   output logic [ENTRY_W-1:0]   mem_wdata,
   output logic [ENTRY_W-1:0]   pde_q,
   output logic [ENTRY_W-1:0]   pte_q,
   output logic                 acc_wr,
   output logic                 acc_user
);

   localparam int unsigned FRAME_W = ENTRY_W - OFF_W;
   localparam int unsigned ESH     = $clog2(ENTRY_W / 8);

   wstate_e              state, nxt;
   logic [LIN_W-1:0]     lin_q;
   logic [ENTRY_W-1:0]   base_q;
   logic                 fin;
   fkind_e               fin_kind;
   logic                 fin_lvl;
   logic [ENTRY_W-1:0]   dir_off;
   logic [OFF_W-1:0]     tbl_off;
   logic [ENTRY_W-1:0]   dir_addr;
   logic [ENTRY_W-1:0]   tbl_addr;

   assign dir_off  = ENTRY_W'(lin_q[LIN_W-1 -: DIR_IDX_W]) << ESH;
   assign tbl_off  = OFF_W'(lin_q[OFF_W +: TBL_IDX_W]) << ESH;
   assign dir_addr = base_q + dir_off;
   assign tbl_addr = {pde_q[ENTRY_W-1 -: FRAME_W], tbl_off};

   assign walk_busy = (state != ST_IDLE);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_RD_DIR: begin mem_req = 1'b1; mem_addr = dir_addr; end
         ST_RD_TBL: begin mem_req = 1'b1; mem_addr = tbl_addr; end
         ST_WR_DIR: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = dir_addr; mem_wdata = dir_wdata;
         end
         ST_WR_TBL: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = tbl_addr; mem_wdata = tbl_wdata;
         end
         default: ;
      endcase
   end

   always_comb begin
      nxt      = state;
      fin      = 1'b0;
      fin_kind = FK_NONE;
      fin_lvl  = 1'b0;
      case (state)
         ST_IDLE:   if (walk_req) nxt = ST_RD_DIR;
         ST_RD_DIR: if (mem_ack) nxt = ST_CHK_DIR;
         ST_CHK_DIR: begin
            if (!lvl_present[0]) begin
               fin = 1'b1; fin_kind = FK_ABSENT;
            end else if (!lvl_allowed[0]) begin
               fin = 1'b1; fin_kind = FK_PROT;
            end else begin
               nxt = ST_RD_TBL;
            end
         end
         ST_RD_TBL: if (mem_ack) nxt = ST_CHK_TBL;
         ST_CHK_TBL: begin
            if (!lvl_present[NUM_LVL-1]) begin
               fin = 1'b1; fin_kind = FK_ABSENT; fin_lvl = 1'b1;
            end else if (!lvl_allowed[NUM_LVL-1]) begin
               fin = 1'b1; fin_kind = FK_PROT; fin_lvl = 1'b1;
            end else if (dir_need) begin
               nxt = ST_WR_DIR;
            end else if (tbl_need) begin
               nxt = ST_WR_TBL;
            end else begin
               fin = 1'b1;
            end
         end
         ST_WR_DIR: if (mem_ack) begin
            if (tbl_need) nxt = ST_WR_TBL;
            else fin = 1'b1;
         end
         ST_WR_TBL: if (mem_ack) fin = 1'b1;
         default: nxt = ST_IDLE;
      endcase
      if (fin) nxt = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         lin_q       <= '0;
         base_q      <= '0;
         acc_wr      <= 1'b0;
         acc_user    <= 1'b0;
         pde_q       <= '0;
         pte_q       <= '0;
         walk_done   <= 1'b0;
         walk_pa     <= '0;
         walk_attr   <= '0;
         walk_fault  <= FK_NONE;
         walk_flevel <= 1'b0;
      end else begin
         state     <= nxt;
         walk_done <= fin;
         if (state == ST_IDLE && walk_req) begin
            lin_q    <= walk_lin;
            base_q   <= dir_base;
            acc_wr   <= walk_wr;
            acc_user <= walk_user;
         end
         if (state == ST_RD_DIR && mem_ack) pde_q <= mem_rdata;
         if (state == ST_RD_TBL && mem_ack) pte_q <= mem_rdata;
         if (fin) begin
            walk_fault  <= fin_kind;
            walk_flevel <= fin_lvl;
            if (fin_kind == FK_NONE) begin
               walk_pa   <= {pte_q[ENTRY_W-1 -: FRAME_W], lin_q[OFF_W-1:0]};
               walk_attr <= tbl_wdata[OFF_W-1:0];
            end else begin
               walk_pa   <= '0;
               walk_attr <= '0;
            end
         end
      end
   end

   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> !walk_done);

   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(walk_busy) |-> walk_done);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !walk_done |-> ($stable(walk_pa) && $stable(walk_fault) && $stable(walk_attr)));

   assert_wb_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[FL_A]);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int unsigned LIN_W             = 32,
   parameter int unsigned DIR_IDX_W         = 10,
   parameter int unsigned TBL_IDX_W         = 10,
   parameter int unsigned OFF_W             = 12,
   parameter int unsigned ENTRY_W           = 32,
   parameter bit          SUPER_WRITE_CHECK = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRY_W-1:0] dir_base,
   input  logic               walk_req,
   input  logic [LIN_W-1:0]   walk_lin,
   input  logic               walk_wr,
   input  logic               walk_user,
   output logic               walk_busy,
   output logic               walk_done,
   output logic [ENTRY_W-1:0] walk_pa,
   output logic [OFF_W-1:0]   walk_attr,
   output logic [1:0]         walk_fault,
   output logic               walk_flevel,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ENTRY_W-1:0] mem_addr,
   output logic [ENTRY_W-1:0] mem_wdata,
   input  logic               mem_ack,
   input  logic [ENTRY_W-1:0] mem_rdata
);

   localparam int unsigned NUM_LVL = 2;
   localparam int unsigned ESH     = $clog2(ENTRY_W / 8);

   generate
      if (DIR_IDX_W + TBL_IDX_W + OFF_W != LIN_W) begin : g_bad_split
         $error("index and offset widths must fill the linear address");
      end
      if (TBL_IDX_W + ESH > OFF_W) begin : g_bad_table
         $error("a table must fit inside one page");
      end
      if (OFF_W <= FL_D || ENTRY_W <= OFF_W) begin : g_bad_entry
         $error("entry must hold the flag field and a frame number");
      end
   endgenerate

   logic [ENTRY_W-1:0] pde_q, pte_q;
   logic               acc_wr, acc_user;
   logic [NUM_LVL-1:0] lvl_present, lvl_allowed;
   logic [2:0]         lvl_pwu [NUM_LVL];
   logic               dir_need, tbl_need;
   logic [ENTRY_W-1:0] dir_wdata, tbl_wdata;

   assign lvl_pwu[0] = {pde_q[FL_U], pde_q[FL_W], pde_q[FL_P]};
   assign lvl_pwu[1] = {pde_q[FL_U] & pte_q[FL_U], pde_q[FL_W] & pte_q[FL_W], pte_q[FL_P]};

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      pgwalk_perm #(.SUPER_WRITE_CHECK(SUPER_WRITE_CHECK)) u_perm (
         .pres_bit (lvl_pwu[g][0]),
         .wr_bit   (lvl_pwu[g][1]),
         .usr_bit  (lvl_pwu[g][2]),
         .acc_wr   (acc_wr),
         .acc_user (acc_user),
         .present  (lvl_present[g]),
         .allowed  (lvl_allowed[g])
      );
   end

   pgwalk_upd #(.ENTRY_W(ENTRY_W)) u_upd (
      .pde       (pde_q),
      .pte       (pte_q),
      .acc_wr    (acc_wr),
      .dir_need  (dir_need),
      .dir_wdata (dir_wdata),
      .tbl_need  (tbl_need),
      .tbl_wdata (tbl_wdata)
   );

   pgwalk_fsm #(
      .LIN_W(LIN_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W),
      .OFF_W(OFF_W), .ENTRY_W(ENTRY_W), .NUM_LVL(NUM_LVL)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .dir_base    (dir_base),
      .walk_req    (walk_req),
      .walk_lin    (walk_lin),
      .walk_wr     (walk_wr),
      .walk_user   (walk_user),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .lvl_present (lvl_present),
      .lvl_allowed (lvl_allowed),
      .dir_need    (dir_need),
      .dir_wdata   (dir_wdata),
      .tbl_need    (tbl_need),
      .tbl_wdata   (tbl_wdata),
      .walk_busy   (walk_busy),
      .walk_done   (walk_done),
      .walk_pa     (walk_pa),
      .walk_attr   (walk_attr),
      .walk_fault  (walk_fault),
      .walk_flevel (walk_flevel),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .pde_q       (pde_q),
      .pte_q       (pte_q),
      .acc_wr      (acc_wr),
      .acc_user    (acc_user)
   );

   assert_no_fault_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (lvl_present == '1 && lvl_allowed == '1));

   assert_fault_enc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> (walk_fault != 2'b11));

   generate
      if (!SUPER_WRITE_CHECK) begin : g_super_chk
         assert_super_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (walk_done && !acc_user) |-> (walk_fault != FK_PROT));
      end
   endgenerate

endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] DIR_BASE = 32'h0000_3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_req = 1'b0;
   logic [31:0] walk_lin = '0;
   logic        walk_wr = 1'b0;
   logic        walk_user = 1'b0;
   logic        walk_busy, walk_done, walk_flevel;
   logic [31:0] walk_pa;
   logic [11:0] walk_attr;
   logic [1:0]  walk_fault;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pgwalk_top dut_i (
      .clk(clk), .rst_n(rst_n), .dir_base(DIR_BASE),
      .walk_req(walk_req), .walk_lin(walk_lin), .walk_wr(walk_wr), .walk_user(walk_user),
      .walk_busy(walk_busy), .walk_done(walk_done), .walk_pa(walk_pa),
      .walk_attr(walk_attr), .walk_fault(walk_fault), .walk_flevel(walk_flevel),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: 16 KB, directory in page 3, tables in pages 0..2
   logic [31:0] mem [0:4095] = '{default: 32'h0};
   logic [31:0] rd_a [0:3] = '{default: 32'h0};
   int          rd_tot = 0;
   int          wr_tot = 0;
   int          lat = 0;
   logic        set_en = 1'b0;
   logic [11:0] set_idx = '0;
   logic [31:0] set_val = '0;

   always @(posedge clk) begin
      if (set_en) mem[set_idx] <= set_val;
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat == 0) begin
            mem_ack <= 1'b1;
            lat <= int'($urandom_range(0, 3));
            if (mem_we) begin
               mem[mem_addr[13:2]] <= mem_wdata;
               wr_tot <= wr_tot + 1;
            end else begin
               mem_rdata <= mem[mem_addr[13:2]];
               rd_a[rd_tot[1:0]] <= mem_addr;
               rd_tot <= rd_tot + 1;
            end
         end else begin
            lat <= lat - 1;
         end
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic poke(input int idx, input logic [31:0] val);
      @(negedge clk);
      set_en = 1'b1; set_idx = idx[11:0]; set_val = val;
      @(negedge clk);
      set_en = 1'b0;
   endtask

   // expected results
   logic [1:0]  e_fault;
   logic        e_lvl;
   logic [31:0] e_pa, e_a0, e_a1, e_pde, e_pte;
   logic [11:0] e_attr;
   int          e_rd, e_wr, e_dix, e_tix;

   task automatic model(input logic [31:0] lin, input logic wr, input logic user);
      logic [31:0] pde, pte;
      e_fault = 2'd0; e_lvl = 1'b0; e_pa = '0; e_attr = '0; e_wr = 0; e_a1 = '0;
      e_dix = 3072 + int'(lin[31:22]);
      e_a0  = DIR_BASE + {20'h0, lin[31:22], 2'b00};
      pde = mem[e_dix]; e_pde = pde; e_rd = 1; e_tix = -1;
      if (!pde[0]) begin
         e_fault = 2'd1;
      end else if (user && (!pde[2] || (wr && !pde[1]))) begin
         e_fault = 2'd2;
      end else begin
         e_rd = 2;
         e_tix = (int'(pde[31:12]) * 1024 + int'(lin[21:12])) % 4096;
         e_a1 = {pde[31:12], lin[21:12], 2'b00};
         pte = mem[e_tix]; e_pte = pte;
         if (!pte[0]) begin
            e_fault = 2'd1; e_lvl = 1'b1;
         end else if (user && (!pte[2] || (wr && !pte[1]))) begin
            e_fault = 2'd2; e_lvl = 1'b1;
         end else begin
            e_pde = pde | 32'h20;
            e_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            e_wr = (e_pde != pde ? 1 : 0) + (e_pte != pte ? 1 : 0);
            e_pa = {pte[31:12], lin[11:0]};
            e_attr = e_pte[11:0];
         end
      end
   endtask

   task automatic run_walk(input logic [31:0] lin, input logic wr, input logic user,
                           input bit poke_busy);
      int rd0, wr0, n;
      logic [31:0] pa_hold;
      model(lin, wr, user);
      @(negedge clk);
      rd0 = rd_tot; wr0 = wr_tot;
      walk_req = 1'b1; walk_lin = lin; walk_wr = wr; walk_user = user;
      @(negedge clk);
      walk_req = 1'b0;
      chk("R9 busy after accept", {31'h0, walk_busy}, 32'h1);
      if (poke_busy) begin
         walk_req = 1'b1; walk_lin = ~lin; walk_wr = ~wr; walk_user = ~user;
         @(negedge clk);
         walk_req = 1'b0;
      end
      n = 0;
      while (!walk_done && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (n >= 200) begin
         errors++; checks++;
         $display("FAIL R9 watchdog: actual no done expected done");
      end
      chk("R9 busy low at done", {31'h0, walk_busy}, 32'h0);
      chk("R4/R5 fault kind", {30'h0, walk_fault}, {30'h0, e_fault});
      chk("R4/R5 fault level", {31'h0, walk_flevel}, {31'h0, e_lvl});
      chk("R3 physical address", walk_pa, e_pa);
      chk("R3 attributes", {20'h0, walk_attr}, {20'h0, e_attr});
      chk("R4 read count", rd_tot - rd0, e_rd);
      chk("R2 directory read address", rd_a[rd0[1:0]], e_a0);
      if (e_rd == 2) chk("R2 table read address", rd_a[(rd0 + 1) % 4], e_a1);
      chk("R8 write count", wr_tot - wr0, e_wr);
      chk("R7 directory entry in memory", mem[e_dix], e_pde);
      if (e_tix >= 0) chk("R7 table entry in memory", mem[e_tix], e_pte);
      pa_hold = walk_pa;
      @(negedge clk);
      chk("R9 done is a pulse", {31'h0, walk_done}, 32'h0);
      chk("R9 result held", walk_pa, pa_hold);
   endtask

   task automatic setup(input int dir, input int tbl, input logic [31:0] pde,
                        input logic [31:0] pte);
      poke(3072 + dir, pde);
      poke((int'(pde[31:12]) * 1024 + tbl) % 4096, pte);
   endtask

   function automatic logic [31:0] mk_lin(input int dir, input int tbl, input int off);
      return {dir[9:0], tbl[9:0], off[11:0]};
   endfunction

   initial begin
      void'($urandom(32'd20041));
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", {31'h0, walk_busy}, 32'h0);
      chk("R1 mem_req in reset", {31'h0, mem_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", {31'h0, walk_done}, 32'h0);
      chk("R1 fault after reset", {30'h0, walk_fault}, 32'h0);
      chk("R1 pa after reset", walk_pa, 32'h0);

      // R4 directory absent
      setup(5, 7, 32'h0000_1006, 32'h1111_1007);
      run_walk(mk_lin(5, 7, 12'h123), 1'b0, 1'b0, 1'b0);
      // R4 table absent
      setup(6, 8, 32'h0000_1007, 32'h1234_5006);
      run_walk(mk_lin(6, 8, 12'h456), 1'b0, 1'b1, 1'b0);
      // R5 user denied at directory
      setup(9, 3, 32'h0000_1003, 32'h2222_2007);
      run_walk(mk_lin(9, 3, 12'h010), 1'b0, 1'b1, 1'b0);
      // R5 user write to read-only table entry, no write-back (R8)
      setup(10, 4, 32'h0000_2007, 32'hABCD_E005);
      run_walk(mk_lin(10, 4, 12'hFFC), 1'b1, 1'b1, 1'b0);
      // R6 supervisor write to read-only, non-user page; R7 both flags set
      setup(11, 5, 32'h0000_2001, 32'hABCD_E001);
      run_walk(mk_lin(11, 5, 12'h004), 1'b1, 1'b0, 1'b0);
      chk("R6 supervisor pa", walk_pa, 32'hABCD_E004);
      chk("R7 table entry gets A and D", mem[2048 + 5], 32'hABCD_E061);
      // R8 flags already set: no writes
      setup(12, 6, 32'h0000_1027, 32'h5555_5067);
      run_walk(mk_lin(12, 6, 12'h800), 1'b1, 1'b1, 1'b0);
      // R7 read with A clear: D stays clear
      setup(13, 9, 32'h0000_0007, 32'h7777_7007);
      run_walk(mk_lin(13, 9, 12'h0AB), 1'b0, 1'b1, 1'b0);
      chk("R7 read leaves dirty clear", {20'h0, walk_attr}, 32'h027);
      // R9 request while busy is dropped
      setup(14, 2, 32'h0000_2001, 32'h3333_3001);
      run_walk(mk_lin(14, 2, 12'h321), 1'b1, 1'b0, 1'b1);

      // random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] lin, pde, pte;
         logic wr, user;
         lin  = $urandom;
         wr   = 1'($urandom_range(0, 1));
         user = 1'($urandom_range(0, 1));
         pde  = {12'h0, 8'($urandom_range(0, 2)), 12'($urandom)};
         pde[0] = ($urandom_range(0, 99) < 85);
         pte  = $urandom;
         pte[0] = ($urandom_range(0, 99) < 85);
         setup(int'(lin[31:22]), int'(lin[21:12]), pde, pte);
         run_walk(lin, wr, user, (i % 37) == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule